// File: doc/BRIEF.md
# Message-Signalled Interrupt Ring Controller

This block turns inbound message-signalled interrupt writes into records in a circular log that lives in system memory. Each inbound message carries a 32-bit data word. The block accepts one message at a time. It then issues a single 16-byte memory write to the ring at the current hardware write position. When that write is accepted, it moves the write position forward by one record and wraps at the ring size.

Software programs the block through a small word-addressed register port. Through this port it sets the 64-bit ring base, enables the block and its interrupt, picks one of four ring sizes, and chooses how a full ring is handled. Software drains the log by reading the hardware write offset, walking the records, and writing its own read offset back. A level-sensitive interrupt stays high for as long as the two offsets differ.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset, the control register, base address, read offset and write offset all read 0, and `msg_ready`, `mem_req_valid` and `irq` are low.
- R2: The register word addresses are: 0 control, 3 base bits 63:32, 4 base bits 31:0, 5 read offset, 6 write offset. Addresses 1, 2 and 7 read 0, and a write to address 6 has no effect.
- R3: The control bits are: 0 block enable, 1 overflow-flag enable, 3 interrupt enable, 4 hold-when-full, 9:8 size code k giving a ring of 2^(15+k) bytes, and 31 sticky overflow. All of them read back as written, except bit 31, which is cleared by writing 1 to it.
- R4: Each stored message produces exactly one memory request. Its address is base + write offset. Its 128-bit data holds the message word in bits 31:0 and zeros in all other bits. Address and data stay stable while `mem_req_valid` waits for `mem_req_ready`.
- R5: When a memory request is accepted, the write offset advances by 16, modulo the ring size. This includes wrapping from the last record back to offset 0 at every ring size.
- R6: A write to the read offset stores the written value ANDed with (size-1) & ~15. The new value is visible from the next cycle.
- R7: The ring is full when (write offset + 16) mod size equals the read offset. While the ring is full and hold-when-full is set, `msg_ready` is low. It rises again once a read offset write frees space.
- R8: While the ring is full and hold-when-full is clear, a message is accepted and discarded: no memory request is made and the write offset does not move. The sticky overflow bit is set only if overflow-flag enable is set.
- R9: `irq` is high exactly when block enable and interrupt enable are both set and the read and write offsets differ.
- R10: With block enable clear, `msg_ready` stays low and no new records are written.
- R11: Changing the size code, or writing either base address register, resets both offsets to 0 on the next cycle.
- R12: At most one record is in flight: `msg_ready` is low while `mem_req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| msg_valid | input | 1 | Inbound message present |
| msg_data | input | 32 | Inbound message data word |
| msg_ready | output | 1 | Block can take a message this cycle |
| mem_req_valid | output | 1 | Memory write request pending |
| mem_req_addr | output | 64 | Byte address of the record |
| mem_req_data | output | 128 | Record contents |
| mem_req_ready | input | 1 | Memory side accepts the request |
| irq | output | 1 | Level interrupt: unread records exist |

## Verification
The assertions assume that the memory side never retracts a request it has not yet taken. They also assume that a base address write or a size change in the middle of a request legitimately moves the request address, so the stability property is suspended in that cycle. They further assume that software writes only 16-byte-aligned offsets within the ring, and that the overflow clear arrives only on a control write. The stimulus changes registers only at negative clock edges. It moves the base and size only while no message is waiting. Its read offset writes are always derived from the bench's own model of where the write offset sits. Back-pressure on the memory side is random, but it never holds a request back indefinitely.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int CODE_W      = 2;
  localparam int ENTRY_BYTES = 16;
  localparam int REG_AW      = 3;

  localparam logic [REG_AW-1:0] A_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] A_BASE_HI = 3'd3;
  localparam logic [REG_AW-1:0] A_BASE_LO = 3'd4;
  localparam logic [REG_AW-1:0] A_RD_OFF  = 3'd5;
  localparam logic [REG_AW-1:0] A_WR_OFF  = 3'd6;

  localparam int B_EN   = 0;
  localparam int B_FLAG = 1;
  localparam int B_IE   = 3;
  localparam int B_STOP = 4;
  localparam int B_CODE = 8;
  localparam int B_OVF  = 31;

  typedef struct packed {
    logic              en;
    logic              flag_en;
    logic              irq_en;
    logic              stop_full;
    logic [CODE_W-1:0] code;
  } cfg_t;

  // byte mask that keeps an offset inside the ring and on a record boundary
  function automatic logic [31:0] ring_mask(input logic [CODE_W-1:0] code, input int min_shift);
    logic [31:0] size;
    size = 32'd1 << (min_shift + int'(code));
    return (size - 32'd1) & ~32'(ENTRY_BYTES - 1);
  endfunction

  function automatic logic [31:0] ring_next(input logic [31:0] off, input logic [31:0] mask);
    return (off + 32'(ENTRY_BYTES)) & mask;
  endfunction
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int OFF_W  = 18,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic              ovf_set,
  output cfg_t              cfg,
  output logic [ADDR_W-1:0] base,
  output logic              ovf,
  output logic              ptr_clear,
  output logic              rd_load,
  output logic [REG_W-1:0]  reg_rdata
);
  logic ctrl_wr, base_wr, ovf_clr;

  assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
  assign base_wr   = reg_wr && ((reg_addr == A_BASE_HI) || (reg_addr == A_BASE_LO));
  assign ovf_clr   = ctrl_wr && reg_wdata[B_OVF];
  assign rd_load   = reg_wr && (reg_addr == A_RD_OFF);
  assign ptr_clear = base_wr || (ctrl_wr && (reg_wdata[B_CODE +: CODE_W] != cfg.code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      base <= '0;
      ovf  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        cfg.en        <= reg_wdata[B_EN];
        cfg.flag_en   <= reg_wdata[B_FLAG];
        cfg.irq_en    <= reg_wdata[B_IE];
        cfg.stop_full <= reg_wdata[B_STOP];
        cfg.code      <= reg_wdata[B_CODE +: CODE_W];
      end
      if (reg_wr && reg_addr == A_BASE_HI) base[ADDR_W-1:REG_W] <= reg_wdata;
      if (reg_wr && reg_addr == A_BASE_LO) base[REG_W-1:0]      <= reg_wdata;
      // a drop in the same cycle as a clear wins
      ovf <= (ovf && !ovf_clr) || ovf_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_EN]               = cfg.en;
        reg_rdata[B_FLAG]             = cfg.flag_en;
        reg_rdata[B_IE]               = cfg.irq_en;
        reg_rdata[B_STOP]             = cfg.stop_full;
        reg_rdata[B_CODE +: CODE_W]   = cfg.code;
        reg_rdata[B_OVF]              = ovf;
      end
      A_BASE_HI: reg_rdata = base[ADDR_W-1:REG_W];
      A_BASE_LO: reg_rdata = base[REG_W-1:0];
      A_RD_OFF:  reg_rdata = REG_W'(rd_off);
      A_WR_OFF:  reg_rdata = REG_W'(wr_off);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_ring_ptrs.sv
module msi_ring_ptrs
  import msi_ring_pkg::*;
#(
  parameter int MIN_SHIFT = 15,
  parameter int OFF_W     = 18,
  parameter int REG_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              ptr_clear,
  input  logic              rd_load,
  input  logic [REG_W-1:0]  rd_load_val,
  input  logic              advance,
  output logic [OFF_W-1:0]  rd_off,
  output logic [OFF_W-1:0]  wr_off,
  output logic [OFF_W-1:0]  mask,
  output logic              full,
  output logic              pending
);
  logic [OFF_W-1:0] wr_next;

  assign mask    = OFF_W'(ring_mask(code, MIN_SHIFT));
  assign wr_next = OFF_W'(ring_next(32'(wr_off), 32'(mask)));
  assign full    = (wr_next == rd_off);
  assign pending = (rd_off != wr_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_off <= '0;
      wr_off <= '0;
    end else if (ptr_clear) begin
      rd_off <= '0;
      wr_off <= '0;
    end else begin
      if (rd_load) rd_off <= OFF_W'(rd_load_val) & mask;
      if (advance) wr_off <= wr_next;
    end
  end
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer #(
  parameter int MSG_W   = 32,
  parameter int ADDR_W  = 64,
  parameter int OFF_W   = 18,
  parameter int ENTRY_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               stop_full,
  input  logic               full,
  input  logic [ADDR_W-1:0]  base,
  input  logic [OFF_W-1:0]   wr_off,
  input  logic               msg_valid,
  input  logic [MSG_W-1:0]   msg_data,
  output logic               msg_ready,
  output logic               msg_acc,
  output logic               msg_drop,
  output logic               mem_req_valid,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [ENTRY_W-1:0] mem_req_data,
  input  logic               mem_req_ready,
  output logic               mem_fire
);
  logic             busy;
  logic [MSG_W-1:0] held;

  assign msg_ready     = en && !busy && !(full && stop_full);
  assign msg_acc       = msg_valid && msg_ready;
  assign msg_drop      = msg_acc && full;
  assign mem_req_valid = busy;
  assign mem_fire      = busy && mem_req_ready;
  assign mem_req_addr  = base + ADDR_W'(wr_off);
  assign mem_req_data  = ENTRY_W'(held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      held <= '0;
    end else begin
      if (mem_fire) busy <= 1'b0;
      if (msg_acc && !full) begin
        busy <= 1'b1;
        held <= msg_data;
      end
    end
  end
endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
  import msi_ring_pkg::*;
#(
  parameter  int MIN_SHIFT = 15,
  parameter  int MSG_W     = 32,
  parameter  int REG_W     = 32,
  localparam int ADDR_W    = 2 * REG_W,
  localparam int ENTRY_W   = ENTRY_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               msg_valid,
  input  logic [MSG_W-1:0]   msg_data,
  output logic               msg_ready,
  output logic               mem_req_valid,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [ENTRY_W-1:0] mem_req_data,
  input  logic               mem_req_ready,
  output logic               irq
);
  localparam int OFF_W = MIN_SHIFT + (1 << CODE_W) - 1;

  cfg_t              cfg;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  rd_off, wr_off, ring_mask_w;
  logic              ovf, ovf_set, ptr_clear, rd_load;
  logic              full, pending, msg_acc, msg_drop, mem_fire;

  assign ovf_set = msg_drop && cfg.flag_en;
  assign irq     = cfg.en && cfg.irq_en && pending;

  msi_ring_regs #(.REG_W(REG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_off(rd_off), .wr_off(wr_off), .ovf_set(ovf_set), .cfg(cfg), .base(base), .ovf(ovf),
    .ptr_clear(ptr_clear), .rd_load(rd_load), .reg_rdata(reg_rdata)
  );

  msi_ring_ptrs #(.MIN_SHIFT(MIN_SHIFT), .OFF_W(OFF_W), .REG_W(REG_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .code(cfg.code), .ptr_clear(ptr_clear), .rd_load(rd_load),
    .rd_load_val(reg_wdata), .advance(mem_fire), .rd_off(rd_off), .wr_off(wr_off),
    .mask(ring_mask_w), .full(full), .pending(pending)
  );

  msi_ring_writer #(.MSG_W(MSG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .stop_full(cfg.stop_full), .full(full),
    .base(base), .wr_off(wr_off), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_ready(msg_ready), .msg_acc(msg_acc), .msg_drop(msg_drop),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_req_ready(mem_req_ready), .mem_fire(mem_fire)
  );
endmodule

// File: rtl/msi_ring_checker.sv
module msi_ring_checker #(
  parameter int OFF_W   = 18,
  parameter int ADDR_W  = 64,
  parameter int ENTRY_W = 128,
  parameter int MSG_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_ready,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic [ENTRY_W-1:0] mem_req_data,
  input logic               irq,
  input logic               en,
  input logic               irq_en,
  input logic               stop_full,
  input logic               full,
  input logic [OFF_W-1:0]   rd_off,
  input logic [OFF_W-1:0]   wr_off,
  input logic [OFF_W-1:0]   mask,
  input logic               ptr_clear,
  input logic               mem_fire,
  input logic               msg_drop,
  input logic               ovf,
  input logic               ovf_clr
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !ptr_clear |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data));

  p_entry_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_data[ENTRY_W-1:MSG_W] == '0));

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire && !ptr_clear |=> wr_off == (($past(wr_off) + OFF_W'(16)) & $past(mask)));

  p_wr_static_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_fire && !ptr_clear |=> $stable(wr_off));

  p_hold_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full && stop_full |-> !msg_ready);

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_drop |=> !mem_req_valid);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);

  p_irq_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_off == wr_off) |-> !irq);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && irq_en) |-> !irq);

  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !msg_ready);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clear |=> (rd_off == '0) && (wr_off == '0));

  p_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !msg_ready);
endmodule

bind msi_ring_ctrl msi_ring_checker #(
  .OFF_W(OFF_W), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .MSG_W(MSG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_ready(msg_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
  .irq(irq), .en(cfg.en), .irq_en(cfg.irq_en), .stop_full(cfg.stop_full), .full(full),
  .rd_off(rd_off), .wr_off(wr_off), .mask(ring_mask_w), .ptr_clear(ptr_clear),
  .mem_fire(mem_fire), .msg_drop(msg_drop), .ovf(ovf),
  .ovf_clr(reg_wr && (reg_addr == 3'd0) && reg_wdata[31])
);

// File: tb/msi_ring_ctrl_test.sv
module msi_ring_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msg_valid = 1'b0;
  logic [31:0]  msg_data = '0;
  logic         msg_ready;
  logic         mem_req_valid;
  logic [63:0]  mem_req_addr;
  logic [127:0] mem_req_data;
  logic         mem_req_ready = 1'b1;
  logic         irq;

  int  n_chk = 0, n_bad = 0;
  bit  chk_on = 0, rdy_rand = 0, done = 0;

  // behavioural model state
  bit          m_en, m_fe, m_ie, m_st, m_ovf, m_pend;
  int unsigned m_code, m_rd, m_wr;
  logic [63:0] m_base;
  logic [31:0] m_pdata;

  always #10 clk = ~clk;

  msi_ring_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_data(msg_data), .msg_ready(msg_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_req_ready(mem_req_ready), .irq(irq)
  );

  function automatic int unsigned msize();
    return 32'd1 << (15 + m_code);
  endfunction
  function automatic bit mfull();
    return ((m_wr + 16) % msize()) == m_rd;
  endfunction
  function automatic bit mready();
    return m_en && !m_pend && !(mfull() && m_st);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit acc, fire, was_full, clr, setf;
    if (!rst_n) begin
      m_en = 0; m_fe = 0; m_ie = 0; m_st = 0; m_ovf = 0; m_pend = 0;
      m_code = 0; m_rd = 0; m_wr = 0; m_base = '0; m_pdata = '0;
    end else begin
      was_full = mfull();
      acc  = msg_valid && mready();
      fire = m_pend && mem_req_ready;
      clr  = 0;
      setf = 0;
      if (fire) begin
        m_pend = 0;
        m_wr = (m_wr + 16) % msize();
      end
      if (acc) begin
        if (was_full) setf = m_fe;
        else begin m_pend = 1; m_pdata = msg_data; end
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin
            clr = (int'(reg_wdata[9:8]) != m_code);
            m_en = reg_wdata[0]; m_fe = reg_wdata[1]; m_ie = reg_wdata[3]; m_st = reg_wdata[4];
            m_code = reg_wdata[9:8];
            if (reg_wdata[31]) m_ovf = 0;
          end
          3'd3: begin m_base[63:32] = reg_wdata; clr = 1; end
          3'd4: begin m_base[31:0] = reg_wdata; clr = 1; end
          3'd5: m_rd = reg_wdata & ((msize() - 1) & ~32'd15);
          default: ;
        endcase
      end
      if (setf) m_ovf = 1;
      if (clr) begin m_rd = 0; m_wr = 0; end
    end
  end

  // comparison against the model on every clock
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      chk(msg_ready == mready(), "R12 msg_ready", 128'(msg_ready), 128'(mready()));
      chk(mem_req_valid == m_pend, "R4 mem_req_valid", 128'(mem_req_valid), 128'(m_pend));
      if (m_pend) begin
        chk(mem_req_addr == m_base + 64'(m_wr), "R4 address", 128'(mem_req_addr), 128'(m_base + 64'(m_wr)));
        chk(mem_req_data == {96'd0, m_pdata}, "R4 record", mem_req_data, {96'd0, m_pdata});
      end
      chk(irq == (m_en && m_ie && (m_rd != m_wr)), "R9 irq", 128'(irq), 128'(m_en && m_ie && (m_rd != m_wr)));
    end
  end

  always @(negedge clk) mem_req_ready <= rdy_rand ? 1'($urandom % 2) : 1'b1;

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #2 reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(reg_rdata == exp, tag, 128'(reg_rdata), 128'(exp));
  endtask

  task automatic send_msg(input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1; msg_data = d;
    while (!msg_ready) @(negedge clk);
    @(posedge clk);
    #2 msg_valid = 0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(!msg_ready && !mem_req_valid && !irq, "R1 outputs in reset", 128'({msg_ready, mem_req_valid, irq}), 128'(0));
    rst_n = 1;
    chk_on = 1;
    // R1 reset values
    rd_reg(3'd0, 32'h0, "R1 ctrl");
    rd_reg(3'd5, 32'h0, "R1 read offset");
    rd_reg(3'd6, 32'h0, "R1 write offset");
    rd_reg(3'd3, 32'h0, "R1 base hi");
    // R2 map holes and read-only write offset
    rd_reg(3'd1, 32'h0, "R2 hole 1");
    rd_reg(3'd2, 32'h0, "R2 hole 2");
    rd_reg(3'd7, 32'h0, "R2 hole 7");
    wr_reg(3'd6, 32'h100);
    rd_reg(3'd6, 32'h0, "R2 write offset read-only");
    wr_reg(3'd3, 32'hA5);
    wr_reg(3'd4, 32'h5A0000);
    rd_reg(3'd3, 32'hA5, "R2 base hi");
    rd_reg(3'd4, 32'h5A0000, "R2 base lo");

    // R5 wrap at every ring size
    for (int c = 0; c < 4; c++) begin
      int unsigned sz, n;
      wr_reg(3'd0, 32'h19 | (32'(c) << 8));
      rd_reg(3'd0, 32'h19 | (32'(c) << 8), "R3 control readback");
      sz = 32'd1 << (15 + c);
      n  = sz / 16 + 3;
      wr_reg(3'd5, (m_wr + sz / 2) % sz);
      for (int i = 0; i < int'(n); i++) begin
        send_msg(32'h1000_0000 + 32'(i));
        if (i % 8 == 7) wr_reg(3'd5, (m_wr + sz / 2) % sz);
      end
      repeat (3) @(negedge clk);
      rd_reg(3'd6, (n * 16) % sz, "R5 wrap offset");
    end

    // R11 base write clears offsets
    wr_reg(3'd3, 32'h12);
    rd_reg(3'd6, 32'h0, "R11 write offset after base write");
    rd_reg(3'd5, 32'h0, "R11 read offset after base write");
    wr_reg(3'd4, 32'h3400_0000);
    // size change to code 0 with hold-when-full
    wr_reg(3'd0, 32'h1B);
    wr_reg(3'd5, 32'd32);
    send_msg(32'hCAFE_0001);
    repeat (2) @(negedge clk);
    rd_reg(3'd6, 32'd16, "R5 one record");
    // R7 hold while full
    @(negedge clk);
    msg_valid = 1; msg_data = 32'hCAFE_0002;
    repeat (5) begin
      @(negedge clk);
      chk(!msg_ready, "R7 held while full", 128'(msg_ready), 128'(0));
    end
    wr_reg(3'd5, 32'd48);
    @(negedge clk);
    chk(msg_ready, "R7 resumes after space frees", 128'(msg_ready), 128'(1));
    @(posedge clk);
    #2 msg_valid = 0;
    repeat (3) @(negedge clk);
    rd_reg(3'd6, 32'd32, "R7 write offset after resume");
    // R8 drop with flag
    wr_reg(3'd0, 32'h0B);
    send_msg(32'hDEAD_0001);
    repeat (2) @(negedge clk);
    rd_reg(3'd6, 32'd32, "R8 dropped record leaves offset");
    rd_reg(3'd0, 32'h8000_000B, "R8 overflow flag set");
    wr_reg(3'd0, 32'h0000_000B);
    rd_reg(3'd0, 32'h8000_000B, "R3 overflow kept on write of 0");
    wr_reg(3'd0, 32'h8000_000B);
    rd_reg(3'd0, 32'h0000_000B, "R3 overflow cleared by write of 1");
    wr_reg(3'd0, 32'h09);
    send_msg(32'hDEAD_0002);
    repeat (2) @(negedge clk);
    rd_reg(3'd0, 32'h09, "R8 no flag when flagging off");
    rd_reg(3'd6, 32'd32, "R8 silent drop leaves offset");
    // R10 disabled
    wr_reg(3'd0, 32'h08);
    @(negedge clk);
    msg_valid = 1; msg_data = 32'hBEEF_0001;
    repeat (4) begin
      @(negedge clk);
      chk(!msg_ready && !irq, "R10 disabled ready and irq", 128'({msg_ready, irq}), 128'(0));
    end
    #2 msg_valid = 0;
    rd_reg(3'd6, 32'd32, "R10 no record while disabled");
    // R9 gating
    wr_reg(3'd0, 32'h01);
    #1 chk(!irq, "R9 irq off without interrupt enable", 128'(irq), 128'(0));
    wr_reg(3'd0, 32'h09);
    #1 chk(irq, "R9 irq with unread records", 128'(irq), 128'(1));
    wr_reg(3'd5, 32'd32);
    @(negedge clk);
    chk(!irq, "R9 irq drops when drained", 128'(irq), 128'(0));
    // R6 read offset masking
    wr_reg(3'd5, 32'hFFFF_FFFF);
    rd_reg(3'd5, 32'h7FF0, "R6 masked read offset");
    // random back-pressure
    wr_reg(3'd0, 32'h19);
    rdy_rand = 1;
    for (int i = 0; i < 40; i++) send_msg(32'h7700_0000 + 32'(i));
    repeat (20) @(negedge clk);
    rdy_rand = 0;
    repeat (3) @(negedge clk);
    rd_reg(3'd6, 32'd32 + 40 * 16, "R4 records under back-pressure");
    // R11 size change clears offsets
    wr_reg(3'd0, 32'h119);
    rd_reg(3'd6, 32'h0, "R11 write offset after size change");
    rd_reg(3'd5, 32'h0, "R11 read offset after size change");
    wr_reg(3'd5, 32'hFFFF_FFFF);
    rd_reg(3'd5, 32'hFFF0, "R6 mask at 64 KB");

    done = 1;
    chk_on = 0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule